// File: doc/BRIEF.md
# Pipelined Delayed-Error Adaptive FIR Filter

This block is an 8-tap adaptive FIR filter built in transposed form. Every clock it takes one signed sample `x_in` and one desired-response sample `d_in`. It produces the filter output and the error between the desired response and that output. The error drives an LMS weight update with a step size of 2^-(1+MU_SHIFT) in Q1.15 terms. The update is applied as an extra arithmetic right shift.

The error does not reach the weights at once. It passes through four register stages: the subtractor register, a private branch register in each tap, the update-product register, and the weight register itself. This fixed adaptation delay lets every multiply sit between registers, so the loop takes a new sample every clock.

A low `in_valid` marks a bubble. Its `x` and `d` enter the datapath as zero, and its error updates no weight. All weights are visible on `w_flat`.

Top module: `tdlms_filter`

## Requirements
Numbers are Q1.15 two's complement. A "rounded product" of a and b with shift s is floor((a*b + 2^(14+s)) / 2^(15+s)), clamped to [-32768, 32767]. Sample n is the one captured at the n-th rising edge after reset is released, counting from 0. Cycle c is the time after edge c.

- R1: With `rst` high at a rising edge, the following edge leaves `y_out`, `e_out`, `out_valid` and every weight on `w_flat` at zero.
- R2: `out_valid` in cycle n+3 equals the `in_valid` captured with sample n. `y_out` and `e_out` for sample n appear in that same cycle.
- R3: y(n) is built from the tap terms p_k = rounded product (s=0) of the weight tap k held in cycle n-k with x(n-k). The terms are added one by one from tap 7 towards tap 0, and every addition saturates.
- R4: e(n) = d(n) - y(n), saturated to 16 bits.
- R5: Tap k's weight in cycle c+1 is the saturated sum of its cycle-c weight and the rounded product (s=MU_SHIFT) of e(c-5) and x(c-5-k). So an error shown on `e_out` reaches the weights three cycles later. Tap k sits at bits [16k+15:16k] of `w_flat`.
- R6: Weights never wrap. Under a diverging input they clamp at 32767 or -32768.
- R7: A sample with `in_valid` low enters as x=0 and d=0, and its error leaves all weights unchanged.
- R8: Trained on a fixed unknown 8-tap system, the mean squared error of a late 64-sample window falls below 1/16 of the first window's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `x_in`/`d_in` as a real sample |
| x_in | input | 16 | Filter input sample, Q1.15 |
| d_in | input | 16 | Desired response, Q1.15 |
| out_valid | output | 1 | `in_valid` delayed to match the outputs |
| y_out | output | 16 | Filter output, Q1.15 |
| e_out | output | 16 | Error d - y, Q1.15 |
| w_flat | output | 128 | All weights, tap k in bits [16k+15:16k] |

## Verification
`y_out`, `e_out` and `out_valid` for a sample are due three cycles after the edge that captured it. A weight change caused by that sample's error is due six cycles after capture. The bench records every driven sample by the index of its capture edge. Its model keeps weights, outputs and errors per cycle index, and at each falling edge it compares the ports with the model entries for cycle c-3 (outputs) and cycle c (weights). Directed checks pin the same offsets with a single impulse: the valid pulse and error at +3, and the first weight step at +6 but not at +5.

// File: rtl/tdlms_pkg.sv
package tdlms_pkg;

  localparam int DW   = 16;
  localparam int FRAC = DW - 1;
  localparam int PW   = 2 * DW + 2;

  typedef logic signed [DW-1:0] sample_t;
  typedef logic signed [PW-1:0] wide_t;

  localparam wide_t WMAX = wide_t'(2 ** (DW - 1) - 1);
  localparam wide_t WMIN = -WMAX - wide_t'(1);

  // Clamp a wide signed value into the sample range.
  function automatic sample_t clamp(input wide_t v);
    if (v > WMAX) return sample_t'(WMAX);
    if (v < WMIN) return sample_t'(WMIN);
    return sample_t'(v);
  endfunction

  // Product of two fractions, rounded half up after a shift of FRAC+sh.
  function automatic sample_t qmul(input sample_t a, input sample_t b, input int sh);
    wide_t p;
    p = wide_t'(a) * wide_t'(b);
    p = p + (wide_t'(1) <<< (FRAC - 1 + sh));
    p = p >>> (FRAC + sh);
    return clamp(p);
  endfunction

  function automatic sample_t sat_add(input sample_t a, input sample_t b);
    return clamp(wide_t'(a) + wide_t'(b));
  endfunction

  function automatic sample_t sat_sub(input sample_t a, input sample_t b);
    return clamp(wide_t'(a) - wide_t'(b));
  endfunction

endpackage

// File: rtl/tdlms_xline.sv
// Delay line of captured samples; output i is the sample captured LAG+i+1 edges ago.
module tdlms_xline import tdlms_pkg::*; #(
  parameter int N_OUT = 8,
  parameter int LAG   = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  sample_t din,
  output sample_t taps [N_OUT]
);
  localparam int DEPTH = N_OUT + LAG;

  sample_t stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else     stage[i] <= stage[i-1];
    end
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_out
    assign taps[i] = stage[i + LAG];
  end
endmodule

// File: rtl/tdlms_front.sv
// Input capture, desired-response alignment, error subtractor, valid pipeline.
module tdlms_front import tdlms_pkg::*; #(
  parameter int Y_LAT = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    in_valid,
  input  sample_t x_in,
  input  sample_t d_in,
  input  sample_t chain_sum,
  output sample_t x_cap,
  output sample_t y_q,
  output sample_t e_q,
  output logic    v_out,
  output logic    upd_go
);
  localparam int VDEPTH = Y_LAT + 1;

  sample_t d_cap;
  sample_t d_dly [Y_LAT];
  logic    v_dly [VDEPTH + 1];
  logic    go_1, go_2;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_cap    <= '0;
      d_cap    <= '0;
      v_dly[0] <= 1'b0;
    end else begin
      x_cap    <= in_valid ? x_in : '0;
      d_cap    <= in_valid ? d_in : '0;
      v_dly[0] <= in_valid;
    end
  end

  for (genvar i = 0; i < Y_LAT; i++) begin : g_dal
    always_ff @(posedge clk) begin
      if (rst)         d_dly[i] <= '0;
      else if (i == 0) d_dly[i] <= d_cap;
      else             d_dly[i] <= d_dly[(i == 0) ? 0 : i-1];
    end
  end

  for (genvar i = 1; i <= VDEPTH; i++) begin : g_val
    always_ff @(posedge clk) begin
      if (rst) v_dly[i] <= 1'b0;
      else     v_dly[i] <= v_dly[i-1];
    end
  end

  // Registered subtractor and output stage; update gate follows error branch + product regs.
  always_ff @(posedge clk) begin
    if (rst) begin
      y_q  <= '0;
      e_q  <= '0;
      go_1 <= 1'b0;
      go_2 <= 1'b0;
    end else begin
      y_q  <= chain_sum;
      e_q  <= sat_sub(d_dly[Y_LAT-1], chain_sum);
      go_1 <= v_dly[VDEPTH];
      go_2 <= go_1;
    end
  end

  assign v_out  = v_dly[VDEPTH];
  assign upd_go = go_2;
endmodule

// File: rtl/tdlms_tap.sv
// One tap: error branch register, update product, weight accumulator,
// filter product register and transposed-chain adder.
module tdlms_tap import tdlms_pkg::*; #(
  parameter int MU_SHIFT = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  sample_t x_now,
  input  sample_t x_old,
  input  sample_t err,
  input  logic    upd_en,
  input  sample_t sum_in,
  output sample_t sum_out,
  output sample_t weight
);
  sample_t err_br, upd_q, prod_q, sum_q, w_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_br <= '0;
      upd_q  <= '0;
      w_q    <= '0;
      prod_q <= '0;
      sum_q  <= '0;
    end else begin
      err_br <= err;
      upd_q  <= qmul(err_br, x_old, MU_SHIFT);
      if (upd_en) w_q <= sat_add(w_q, upd_q);
      prod_q <= qmul(w_q, x_now, 0);
      sum_q  <= sat_add(prod_q, sum_in);
    end
  end

  assign sum_out = sum_q;
  assign weight  = w_q;
endmodule

// File: rtl/tdlms_filter.sv
module tdlms_filter import tdlms_pkg::*; #(
  parameter int N_TAPS   = 8,
  parameter int MU_SHIFT = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic signed [DW-1:0]   x_in,
  input  logic signed [DW-1:0]   d_in,
  output logic                   out_valid,
  output logic signed [DW-1:0]   y_out,
  output logic signed [DW-1:0]   e_out,
  output logic [N_TAPS*DW-1:0]   w_flat
);
  // Registers from capture to subtractor output: capture, product, chain.
  localparam int Y_LAT = 2;
  localparam int X_LAG = Y_LAT + 1;

  sample_t x_cap, err_q;
  sample_t x_hist [N_TAPS];
  sample_t chain  [N_TAPS + 1];
  logic    upd_fire;

  assign chain[N_TAPS] = '0;

  tdlms_front #(.Y_LAT(Y_LAT)) u_front (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
    .chain_sum(chain[0]), .x_cap(x_cap), .y_q(y_out), .e_q(err_q),
    .v_out(out_valid), .upd_go(upd_fire)
  );

  tdlms_xline #(.N_OUT(N_TAPS), .LAG(X_LAG)) u_xline (
    .clk(clk), .rst(rst), .din(x_cap), .taps(x_hist)
  );

  for (genvar k = 0; k < N_TAPS; k++) begin : g_tap
    sample_t w_k;
    tdlms_tap #(.MU_SHIFT(MU_SHIFT)) u_tap (
      .clk(clk), .rst(rst), .x_now(x_cap), .x_old(x_hist[k]), .err(err_q),
      .upd_en(upd_fire), .sum_in(chain[k+1]), .sum_out(chain[k]), .weight(w_k)
    );
    assign w_flat[k*DW +: DW] = w_k;
  end

  assign e_out = err_q;
endmodule

// File: rtl/tdlms_filter_chk.sv
module tdlms_filter_chk import tdlms_pkg::*; #(
  parameter int N_TAPS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] d_in,
  input logic                 out_valid,
  input logic signed [DW-1:0] y_out,
  input logic signed [DW-1:0] e_out,
  input logic [N_TAPS*DW-1:0] w_flat,
  input logic                 upd_fire
);
  logic [2:0] age;
  always_ff @(posedge clk) begin
    if (rst)              age <= '0;
    else if (age != 3'd7) age <= age + 3'd1;
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (w_flat == '0 && y_out == '0 && e_out == '0 && !out_valid));

  // R2
  valid_align_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R4
  err_form_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd4 && out_valid) |-> (e_out == sat_sub($past(d_in, 4), y_out)));

  // R5
  fire_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 3'd2) |-> (upd_fire == $past(out_valid, 2)));

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_fire |=> $stable(w_flat));
endmodule

bind tdlms_filter tdlms_filter_chk #(.N_TAPS(N_TAPS)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .d_in(d_in), .out_valid(out_valid),
  .y_out(y_out), .e_out(e_out), .w_flat(w_flat), .upd_fire(upd_fire)
);

// File: tb/tdlms_filter_tb.sv
`timescale 1ns/1ps
module tdlms_filter_tb;
  localparam int NT = 8;
  localparam int MUS = 2;
  localparam int MAXC = 2048;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] x_in = '0;
  logic signed [15:0] d_in = '0;
  logic out_valid;
  logic signed [15:0] y_out, e_out;
  logic [NT*16-1:0] w_flat;

  int n_chk = 0, n_err = 0, cyc = -1;
  int xs[MAXC], ds[MAXC], vs[MAXC], ys[MAXC], es[MAXC];
  int ws[MAXC][NT];
  logic [31:0] rng = 32'h1234_5678;

  always #2.5 clk = ~clk;

  tdlms_filter #(.N_TAPS(NT), .MU_SHIFT(MUS)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .d_in(d_in),
    .out_valid(out_valid), .y_out(y_out), .e_out(e_out), .w_flat(w_flat)
  );

  function automatic int lim(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int rmul(int a, int b, int s);
    longint p = longint'(a) * longint'(b) + (longint'(1) <<< (14 + s));
    return lim(p >>> (15 + s));
  endfunction

  function automatic int gx(int i); return (i < 0) ? 0 : xs[i]; endfunction
  function automatic int gv(int i); return (i < 0) ? 0 : vs[i]; endfunction
  function automatic int gy(int i); return (i < 0) ? 0 : ys[i]; endfunction
  function automatic int ge(int i); return (i < 0) ? 0 : es[i]; endfunction
  function automatic int gw(int i, int k); return (i < 0) ? 0 : ws[i][k]; endfunction
  function automatic int wport(int k); return int'($signed(w_flat[k*16 +: 16])); endfunction

  function automatic int next_rand();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    return int'(rng);
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Model of cycle c: weights held in c, then output/error of sample c.
  task automatic model(int c);
    int acc;
    int n = c - 6;
    for (int k = 0; k < NT; k++) begin
      int base = gw(c - 1, k);
      if (n >= 0 && vs[n] != 0) ws[c][k] = lim(longint'(base) + rmul(es[n], gx(n - k), MUS));
      else ws[c][k] = base;
    end
    acc = rmul(gw(c - (NT - 1), NT - 1), gx(c - (NT - 1)), 0);
    for (int k = NT - 2; k >= 0; k--) acc = lim(longint'(acc) + rmul(gw(c - k, k), gx(c - k), 0));
    ys[c] = acc;
    es[c] = lim(longint'(ds[c]) - acc);
  endtask

  task automatic step(int x, int d, bit v);
    int cur = cyc + 1;
    xs[cur] = v ? x : 0;
    ds[cur] = v ? d : 0;
    vs[cur] = v;
    x_in = 16'(x);
    d_in = 16'(d);
    in_valid = v;
    @(posedge clk);
    cyc = cur;
    model(cyc);
    @(negedge clk);
    chk(int'(out_valid) == gv(cyc - 3), "R2", "out_valid", out_valid, gv(cyc - 3));
    chk(int'(y_out) == gy(cyc - 3), "R3", "y_out", y_out, gy(cyc - 3));
    chk(int'(e_out) == ge(cyc - 3), "R4", "e_out", e_out, ge(cyc - 3));
    for (int k = 0; k < NT; k++)
      chk(wport(k) == ws[cyc][k], "R5", "weight", wport(k), ws[cyc][k]);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; x_in = '0; d_in = '0;
    repeat (3) @(negedge clk);
    chk(y_out == 0, "R1", "y_out after reset", y_out, 0);
    chk(e_out == 0, "R1", "e_out after reset", e_out, 0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(w_flat == '0, "R1", "weights after reset", (w_flat == '0) ? 0 : 1, 0);
    rst = 1'b0;
    cyc = -1;
  endtask

  task automatic t_impulse();
    apply_reset();
    step(16384, 16384, 1'b1);
    for (int i = 0; i < 8; i++) begin
      step(0, 0, 1'b0);
      if (cyc == 2) chk(out_valid == 1'b0, "R2", "impulse valid early", out_valid, 0);
      if (cyc == 3) begin
        chk(out_valid == 1'b1, "R2", "impulse valid at +3", out_valid, 1);
        chk(e_out == 16384, "R4", "impulse error", e_out, 16384);
      end
      if (cyc == 5) chk(wport(0) == 0, "R5", "w0 before +6", wport(0), 0);
      if (cyc == 6) begin
        chk(wport(0) == 2048, "R5", "w0 at +6", wport(0), 2048);
        chk(wport(1) == 0, "R5", "w1 untouched", wport(1), 0);
      end
    end
  endtask

  task automatic t_identify();
    int h[NT] = '{12000, -8000, 5000, 3000, -2000, 1000, 500, -300};
    int raw[NT];
    longint first_e = 0, late_e = 0;
    int snap[NT];
    apply_reset();
    for (int k = 0; k < NT; k++) raw[k] = 0;
    for (int n = 0; n < 1500; n++) begin
      longint s = 0;
      int r = next_rand();
      for (int k = NT - 1; k > 0; k--) raw[k] = raw[k-1];
      raw[0] = int'($signed(16'(r))) >>> 2;
      for (int k = 0; k < NT; k++) s += longint'(h[k]) * raw[k];
      step(raw[0], lim(s >>> 15), (n % 11) != 5);
      if (cyc - 3 >= 0 && cyc - 3 < 64 && out_valid) first_e += longint'(e_out) * e_out;
      if (cyc - 3 >= 1400 && cyc - 3 < 1464 && out_valid) late_e += longint'(e_out) * e_out;
    end
    chk(late_e * 16 < first_e, "R8", "late error energy x16 vs early", late_e * 16, first_e);
    // Bubbles with large values: nothing may reach the weights.
    for (int i = 0; i < 6; i++) step(30000, -30000, 1'b0);
    for (int k = 0; k < NT; k++) snap[k] = wport(k);
    for (int i = 0; i < 10; i++) step(30000, -30000, 1'b0);
    for (int k = 0; k < NT; k++) chk(wport(k) == snap[k], "R7", "weight across bubbles", wport(k), snap[k]);
    chk(y_out == 0, "R7", "y_out from masked x", y_out, 0);
    chk(e_out == 0, "R7", "e_out from masked d", e_out, 0);
    chk(out_valid == 1'b0, "R7", "out_valid for bubbles", out_valid, 0);
  endtask

  task automatic t_saturate();
    bit railed = 1'b0;
    apply_reset();
    for (int n = 0; n < 400; n++) begin
      int r = next_rand();
      step((r & 1) ? 32767 : -32767, int'($signed(16'(r >>> 16))), 1'b1);
      for (int k = 0; k < NT; k++) if (wport(k) == 32767 || wport(k) == -32768) railed = 1'b1;
    end
    chk(railed, "R6", "a weight reached a rail", railed, 1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
    $finish;
  end

  initial begin
    t_impulse();
    t_identify();
    t_saturate();
    apply_reset();   // R1 after a saturated run
    report();
    $finish;
  end
endmodule